// File: doc/BRIEF.md
# Receive FIFO Burst-Read Host Port

This block is a synchronous slave on an asynchronous host bus. It lets an external processor drain a receive data queue by issuing read strobes back to back. It decodes no address beyond a queue-select pin. The active-low chip select and read enable, the queue select and the address inputs are all passed through two-flop synchronizers on the system clock. A read cycle is recognised only when both strobes are seen low. It is closed only when the strobes have been seen released for two consecutive samples.

When a cycle opens with queue select high, the head word of the queue is captured and driven with its output enables. When the cycle closes, the queue advances by one word. The bus can be 32 bits wide, or it can run in a 16-bit mode. In 16-bit mode address bit 1 picks the half-word, and only the upper-half read advances the queue. A read of an empty queue returns zero and sets a sticky underflow flag.

The queue is filled from the receive side through a valid/ready write stream. A word moves only in a cycle where both `wr_valid` and `wr_ready` are high. `wr_ready` falls while the queue is full, so a writer simply holds its word until space returns.

Top module: `rxq_burst_port`

## Requirements
- R1: A read cycle opens only after chip select and read enable are both sampled low with queue select high; the two strobes may fall in either order.
- R2: A cycle closes only after the strobes have been sampled not-both-low on two consecutive clocks; a release lasting one clock neither closes the cycle nor advances the queue. Either strobe may rise first.
- R3: In 32-bit mode (`mode_16`=0), each closed cycle removes exactly one word, and successive cycles return queued words in arrival order.
- R4: Address bits 7 down to 2 have no effect on returned data or on how the queue advances.
- R5: In 16-bit mode (`mode_16`=1), `addr[1]`=0 returns bits 15:0 and `addr[1]`=1 returns bits 31:16 of the head word on `data_out[15:0]`; the queue advances only when a cycle with `addr[1]`=1 closes.
- R6: In 16-bit mode, `data_oe_hi` stays low and `data_out[31:16]` is zero.
- R7: `data_oe_lo` (and `data_oe_hi` in 32-bit mode) is high only while an opened cycle is active. It falls within three clocks of the first strobe release and is low after reset.
- R8: A cycle that opens on an empty queue drives zero, removes nothing and sets `uf_flag`; `uf_flag` stays set until `uf_clr` is pulsed and is low after reset.
- R9: `wr_ready` is high after reset and low while the queue holds DEPTH words; a word offered while `wr_ready` is low is not stored.
- R10: A strobe cycle with queue select low drives no enable and removes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Write stream word valid |
| wr_ready | output | 1 | Queue can accept a word |
| wr_data | input | 32 | Write stream word |
| cs_n | input | 1 | Host chip select, active low |
| rd_n | input | 1 | Host read enable, active low |
| fsel | input | 1 | Queue select, treated as an address line |
| addr | input | 7 | Host address bits 7:1 |
| mode_16 | input | 1 | 1 selects the 16-bit bus |
| data_out | output | 32 | Read data |
| data_oe_lo | output | 1 | Output enable for bits 15:0 |
| data_oe_hi | output | 1 | Output enable for bits 31:16 |
| uf_flag | output | 1 | Sticky empty-read flag |
| uf_clr | input | 1 | Clears uf_flag |

## Verification
A corrupted read or write pointer shows on the very next read cycle as a returned word that breaks arrival order. A counting error shows as a `wr_ready` that falls at the wrong fill level, or as a spurious or missing `uf_flag` on a drain. A cycle state machine that closes too early shows as a skipped word after a one-clock strobe glitch. One that never closes shows as enables still high a few clocks after release. Each read is compared against a queue model, so a fault surfaces within the cycle that exposes it.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE    = 2'd0,
    CYC_ACTIVE  = 2'd1,
    CYC_RELEASE = 2'd2
  } cyc_state_t;
endpackage

// File: rtl/rxq_sync.sv
module rxq_sync #(
  parameter int unsigned W = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= RST_VAL[i];
        s2 <= RST_VAL[i];
      end else begin
        s1 <= d[i];
        s2 <= s1;
      end
    end
    assign q[i] = s2;
  end
endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          empty
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_IX  = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign in_ready = (cnt != FULL_CNT);
  assign empty    = (cnt == '0);
  assign do_push  = in_valid && in_ready;
  assign do_pop   = pop && !empty;
  assign head     = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == LAST_IX) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == LAST_IX) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/rxq_cycle_fsm.sv
module rxq_cycle_fsm
  import rxq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic strb_on,
  input  logic fsel_s,
  input  logic a1_s,
  input  logic mode_16,
  input  logic fifo_empty,
  output logic cyc_start,
  output logic drive,
  output logic pop,
  output logic uf_set
);
  cyc_state_t state;
  logic mine_q, a1_q, empty_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= CYC_IDLE;
      mine_q  <= 1'b0;
      a1_q    <= 1'b0;
      empty_q <= 1'b0;
    end else begin
      case (state)
        CYC_IDLE: if (strb_on) begin
          state   <= CYC_ACTIVE;
          mine_q  <= fsel_s;
          a1_q    <= a1_s;
          empty_q <= fifo_empty;
        end
        CYC_ACTIVE:  if (!strb_on) state <= CYC_RELEASE;
        CYC_RELEASE: state <= strb_on ? CYC_ACTIVE : CYC_IDLE;
        default:     state <= CYC_IDLE;
      endcase
    end
  end

  assign cyc_start = (state == CYC_IDLE) && strb_on && fsel_s;
  assign uf_set    = cyc_start && fifo_empty;
  assign drive     = (state == CYC_ACTIVE) && mine_q;
  assign pop       = (state == CYC_RELEASE) && !strb_on && mine_q && !empty_q
                     && (!mode_16 || a1_q);
endmodule

// File: rtl/rxq_burst_port.sv
module rxq_burst_port #(
  parameter int unsigned BUS_W = 32,
  parameter int unsigned DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [BUS_W-1:0] wr_data,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             fsel,
  input  logic [7:1]       addr,
  input  logic             mode_16,
  output logic [BUS_W-1:0] data_out,
  output logic             data_oe_lo,
  output logic             data_oe_hi,
  output logic             uf_flag,
  input  logic             uf_clr
);
  localparam int unsigned HALF = BUS_W / 2;

  logic [3:0]       sync_q;
  logic             strb_on, fsel_s, a1_s;
  logic [BUS_W-1:0] head;
  logic             fifo_empty, fifo_pop, cyc_start, drive, uf_set;
  logic [BUS_W-1:0] data_q;
  logic             unused_addr;

  assign unused_addr = ^addr[7:2];

  rxq_sync #(.W(4), .RST_VAL(4'b1100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({cs_n, rd_n, fsel, addr[1]}),
    .q(sync_q)
  );
  assign strb_on = !sync_q[3] && !sync_q[2];
  assign fsel_s  = sync_q[1];
  assign a1_s    = sync_q[0];

  rxq_fifo #(.DW(BUS_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .in_valid(wr_valid), .in_ready(wr_ready), .in_data(wr_data),
    .pop(fifo_pop), .head(head), .empty(fifo_empty)
  );

  rxq_cycle_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .strb_on(strb_on), .fsel_s(fsel_s), .a1_s(a1_s),
    .mode_16(mode_16), .fifo_empty(fifo_empty),
    .cyc_start(cyc_start), .drive(drive), .pop(fifo_pop), .uf_set(uf_set)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (cyc_start) begin
      if (fifo_empty)   data_q <= '0;
      else if (mode_16) data_q <= {{HALF{1'b0}}, a1_s ? head[BUS_W-1:HALF] : head[HALF-1:0]};
      else              data_q <= head;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       uf_flag <= 1'b0;
    else if (uf_set)  uf_flag <= 1'b1;
    else if (uf_clr)  uf_flag <= 1'b0;
  end

  assign data_out   = data_q;
  assign data_oe_lo = drive;
  assign data_oe_hi = drive && !mode_16;
endmodule

// File: rtl/rxq_burst_chk.sv
module rxq_burst_chk #(
  parameter int unsigned BUS_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_16,
  input logic             strb_on,
  input logic             fifo_pop,
  input logic             wr_ready,
  input logic             data_oe_lo,
  input logic             data_oe_hi,
  input logic             uf_flag,
  input logic             uf_clr,
  input logic [BUS_W-1:0] data_out
);
  // R1: enables rise only after the strobes were seen both low
  p_start_both_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_oe_lo) |-> $past(strb_on));
  // R2: a queue advance needs two released samples in a row
  p_end_two_samples_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> (!strb_on && $past(!strb_on)));
  // R3: one advance per closed cycle
  p_single_pop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |=> !fifo_pop);
  // R6: upper lanes stay off in 16-bit mode
  p_hi_off_16_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_16 && $past(mode_16)) |-> !data_oe_hi);
  // R7: never driving while the queue advances
  p_no_drive_at_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> !data_oe_lo);
  // R8: empty reads return zero; flag is sticky
  p_zero_on_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uf_flag) |-> (data_out == '0));
  p_uf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (uf_flag && !uf_clr) |=> uf_flag);
  // R9: a full queue stays full until something is read
  p_full_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ready && !fifo_pop) |=> !wr_ready);
endmodule

bind rxq_burst_port rxq_burst_chk #(.BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_16(mode_16), .strb_on(strb_on),
  .fifo_pop(fifo_pop), .wr_ready(wr_ready), .data_oe_lo(data_oe_lo),
  .data_oe_hi(data_oe_hi), .uf_flag(uf_flag), .uf_clr(uf_clr),
  .data_out(data_out)
);

// File: tb/sim_rxq_burst_port.sv
`timescale 1ns/1ps
module sim_rxq_burst_port;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [31:0] wr_data = '0;
  logic        cs_n = 1'b1, rd_n = 1'b1, fsel = 1'b0;
  logic [7:1]  addr = '0;
  logic        mode_16 = 1'b0;
  logic [31:0] data_out;
  logic        data_oe_lo, data_oe_hi, uf_flag;
  logic        uf_clr = 1'b0;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] q[$];

  always #2 clk = ~clk;

  rxq_burst_port #(.BUS_W(32), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .cs_n(cs_n), .rd_n(rd_n), .fsel(fsel), .addr(addr),
    .mode_16(mode_16), .data_out(data_out), .data_oe_lo(data_oe_lo),
    .data_oe_hi(data_oe_hi), .uf_flag(uf_flag), .uf_clr(uf_clr)
  );

  function automatic logic [31:0] exp_half(input logic [31:0] w, input bit a1);
    return a1 ? {16'h0, w[31:16]} : {16'h0, w[15:0]};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] w);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = w;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
    q.push_back(w);
  endtask

  // one full read cycle; d/ohi/olo sampled mid-cycle, olo_end after close
  task automatic rd(input bit fs, input logic [7:1] a, input bit cs_first, input bit cs_rise_first,
                    output logic [31:0] d, output logic olo, output logic ohi, output logic olo_end);
    @(negedge clk); fsel = fs; addr = a;
    @(negedge clk); if (cs_first) cs_n = 1'b0; else rd_n = 1'b0;
    @(negedge clk); cs_n = 1'b0; rd_n = 1'b0;
    repeat (4) @(negedge clk);
    d = data_out; olo = data_oe_lo; ohi = data_oe_hi;
    if (cs_rise_first) cs_n = 1'b1; else rd_n = 1'b1;
    @(negedge clk); cs_n = 1'b1; rd_n = 1'b1;
    repeat (5) @(negedge clk);
    olo_end = data_oe_lo;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, e;
    logic olo, ohi, oend;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!data_oe_lo && !data_oe_hi, "R7 reset enables", {30'h0, data_oe_hi, data_oe_lo}, 0);
    check(!uf_flag, "R8 reset flag", uf_flag, 0);
    check(wr_ready, "R9 reset ready", wr_ready, 1);

    // R1 / R3 / R4 directed: both strobe orders, both release orders
    push(32'hA1B2C3D4); push(32'h11223344); push(32'hDEADBEEF); push(32'h0F0F0F0F);
    for (int k = 0; k < 4; k++) begin
      e = q.pop_front();
      rd(1'b1, {5'(k * 7 + 3), 2'b00}, k[0], k[1], d, olo, ohi, oend);
      check(d == e, "R1 R3 ordered word", d, e);
      check(olo && ohi, "R1 enables during cycle", {30'h0, ohi, olo}, 3);
      check(!oend, "R7 enable released", oend, 0);
    end

    // R4: upper address bits differ, data order unaffected
    push(32'h55AA55AA); push(32'h12345678);
    e = q.pop_front(); rd(1'b1, 7'b1111100, 1, 0, d, olo, ohi, oend);
    check(d == e, "R4 addr ignored", d, e);
    e = q.pop_front(); rd(1'b1, 7'b0101000, 0, 1, d, olo, ohi, oend);
    check(d == e, "R4 addr ignored", d, e);

    // R10: queue select low
    push(32'hCAFEF00D);
    rd(1'b0, 7'h0, 1, 1, d, olo, ohi, oend);
    check(!olo && !ohi, "R10 no drive", {30'h0, ohi, olo}, 0);
    e = q.pop_front(); rd(1'b1, 7'h0, 1, 1, d, olo, ohi, oend);
    check(d == e, "R10 no pop", d, e);

    // R2: one-clock release glitch does not close the cycle
    push(32'h01010101); push(32'h02020202);
    @(negedge clk); fsel = 1'b1;
    @(negedge clk); cs_n = 1'b0; rd_n = 1'b0;
    repeat (4) @(negedge clk);
    rd_n = 1'b1;
    @(negedge clk); rd_n = 1'b0;
    repeat (4) @(negedge clk);
    e = q.pop_front();
    check(data_out == e && data_oe_lo, "R2 glitch keeps cycle", data_out, e);
    cs_n = 1'b1; rd_n = 1'b1;
    repeat (6) @(negedge clk);
    e = q.pop_front(); rd(1'b1, 7'h0, 0, 0, d, olo, ohi, oend);
    check(d == e, "R2 single pop after glitch", d, e);

    // random burst traffic, 32-bit
    for (int it = 0; it < 30; it++) begin
      int np, nr;
      np = $urandom_range(0, 3);
      for (int j = 0; j < np; j++) if (q.size() < DEPTH) push($urandom());
      nr = $urandom_range(0, q.size());
      for (int j = 0; j < nr; j++) begin
        e = q.pop_front();
        rd(1'b1, 7'($urandom()), 1'($urandom()), 1'($urandom()), d, olo, ohi, oend);
        check(d == e, "R3 random burst", d, e);
      end
    end
    while (q.size() > 0) begin
      e = q.pop_front(); rd(1'b1, 7'h0, 1, 0, d, olo, ohi, oend);
      check(d == e, "R3 drain", d, e);
    end

    // R8: empty read
    rd(1'b1, 7'h0, 1, 1, d, olo, ohi, oend);
    check(d == 32'h0, "R8 empty reads zero", d, 0);
    check(uf_flag, "R8 flag set", uf_flag, 1);
    push(32'h77778888);
    repeat (3) @(negedge clk);
    check(uf_flag, "R8 flag sticky", uf_flag, 1);
    e = q.pop_front(); rd(1'b1, 7'h0, 0, 0, d, olo, ohi, oend);
    check(d == e, "R8 empty read did not pop", d, e);
    @(negedge clk); uf_clr = 1'b1;
    @(negedge clk); uf_clr = 1'b0;
    @(negedge clk);
    check(!uf_flag, "R8 flag cleared", uf_flag, 0);

    // R9: fill to full, offer one extra word
    for (int j = 0; j < DEPTH; j++) push(32'hF000_0000 + 32'(j));
    @(negedge clk);
    check(!wr_ready, "R9 full ready low", wr_ready, 0);
    wr_valid = 1'b1; wr_data = 32'hBAD0BAD0;
    repeat (3) @(negedge clk);
    wr_valid = 1'b0;
    while (q.size() > 0) begin
      e = q.pop_front(); rd(1'b1, 7'h0, 1, 1, d, olo, ohi, oend);
      check(d == e, "R9 stored words", d, e);
    end
    rd(1'b1, 7'h0, 1, 1, d, olo, ohi, oend);
    check(d == 32'h0 && uf_flag, "R9 extra word dropped", d, 0);
    @(negedge clk); uf_clr = 1'b1;
    @(negedge clk); uf_clr = 1'b0;

    // R5 / R6: 16-bit mode
    @(negedge clk); mode_16 = 1'b1;
    push(32'hBEEF1234); push(32'h5678CAFE); push(32'h9ABC0DEF);
    for (int j = 0; j < 3; j++) begin
      rd(1'b1, 7'($urandom()) & 7'b1111110, 1'($urandom()), 1'($urandom()), d, olo, ohi, oend);
      check(d == exp_half(q[0], 0), "R5 low half", d, exp_half(q[0], 0));
      check(!ohi && olo, "R6 upper undriven", {30'h0, ohi, olo}, 1);
      rd(1'b1, 7'h0, 0, 0, d, olo, ohi, oend);
      check(d == exp_half(q[0], 0), "R5 low half no pop", d, exp_half(q[0], 0));
      e = q.pop_front();
      rd(1'b1, 7'($urandom()) | 7'b0000001, 1'($urandom()), 1'($urandom()), d, olo, ohi, oend);
      check(d == exp_half(e, 1), "R5 high half", d, exp_half(e, 1));
      check(!ohi && d[31:16] == 16'h0, "R6 upper zero", d, exp_half(e, 1));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule